// File: doc/BRIEF.md
# Multi-Output Level Interrupt Aggregator

This block gathers level-sensitive interrupt sources, organised as up to four 32-bit words, and drives several parent interrupt lines from them. Each word has a writable enable register and a read-only status register. Every parent has its own per-word routing mask, so a parent raises its line only for the sources assigned to it. Sources that no parent covers are treated as absent. They read as zero in status and cannot be enabled.

There is no acknowledge. A source stays pending for as long as its level is high, and the parent line drops once every contributing source has gone low or been masked. At reset each enable register loads a forwarding mask set by a parameter. While the suspend input is high, a set of wake-capable sources is added to the effective enable. The stored enable is left untouched, so it applies again as soon as suspend drops.

Software reaches the registers over a simple word-addressed bus. Read data appears one cycle after the address is presented.

Top module: `lvl_irq_aggregator`

## Requirements
- R1: Word w's enable register is at bus word address 2w (byte offset 0x00 of the pair) and its status register at 2w+1 (byte offset 0x04), so address bit 0 selects status.
- R2: A bus write to an enable address stores the write data ANDed with that word's routed-source mask; reading it back returns the stored value.
- R3: During and after reset, parent outputs and read data are zero, and each word's enable equals its forwarding mask ANDed with the routed-source mask.
- R4: Status reads return the raw source levels ANDed with the routed-source mask; writes to a status address leave every enable unchanged.
- R5: Parent p's output, registered one cycle after its inputs, is 1 when for some word the AND of source levels, effective enable and route mask (p, w) is nonzero.
- R6: Route masks form a flat vector in which word w of parent p is at slot p*NUM_WORDS+w, so all words of parent 0 come first; by default every mask is all ones.
- R7: While suspend is high the effective enable is the stored enable ORed with the wake set ANDed with routed sources; writes still update the stored enable, and when suspend drops the stored enable alone applies.
- R8: Addresses whose word index is at or above NUM_WORDS read as zero, and writes to them have no effect.
- R9: There is no acknowledge: a parent output stays high for as long as a routed, enabled source is held high, and it falls one cycle after the source drops.
- R10: Read data is registered and reflects the address and register state present at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_WORDS*32 | Synchronous source levels, word w at bits [32w+31:32w] |
| suspend | input | 1 | High adds the wake set to the effective enable |
| bus_addr | input | ADDR_W | Word address (bit 0 selects status, upper bits select the word) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| parent_irq | output | NUM_PARENTS | Parent interrupt lines |

## Verification
Both parent outputs and read data are due exactly one clock edge after the inputs that cause them. An enable write becomes visible to both outputs one edge later than the write itself. The bench drives a stimulus on a falling edge and samples on the next falling edge. It compares each sample with a value computed from the sources, suspend and modelled enables that were present at the rising edge in between. Only after that comparison does it apply any write to its enable model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int WORD_W    = 32;
    localparam int MAX_WORDS = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_route_mask.sv
// Unpacks the flat route parameter and derives the set of sources any parent covers.
module irq_route_mask
    import irq_agg_pkg::*;
#(
    parameter int NUM_WORDS   = 2,
    parameter int NUM_PARENTS = 2,
    parameter logic [NUM_PARENTS*NUM_WORDS*WORD_W-1:0] ROUTE_MASK = '1
) (
    output logic [NUM_PARENTS*NUM_WORDS*WORD_W-1:0] route_o,
    output logic [NUM_WORDS*WORD_W-1:0]             routed_o
);
    localparam int SRC_W = NUM_WORDS * WORD_W;

    assign route_o = ROUTE_MASK;

    // A source is routed when at least one parent's mask covers it.
    always_comb begin
        routed_o = '0;
        for (int p = 0; p < NUM_PARENTS; p++) begin
            routed_o = routed_o | ROUTE_MASK[p*SRC_W +: SRC_W];
        end
    end
endmodule

// File: rtl/irq_agg_regbank.sv
// Enable registers, status view and registered read mux.
module irq_agg_regbank
    import irq_agg_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 3,
    parameter logic [NUM_WORDS*WORD_W-1:0] FWD_MASK = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  word_t                       bus_wdata,
    input  logic [NUM_WORDS*WORD_W-1:0] src_lvl,
    input  logic [NUM_WORDS*WORD_W-1:0] routed,
    output logic [NUM_WORDS*WORD_W-1:0] en_o,
    output word_t                       rdata_o
);
    localparam int SRC_W  = NUM_WORDS * WORD_W;
    localparam int WIDX_W = ADDR_W - 1;

    typedef struct packed {
        logic [SRC_W-1:0] en;
        word_t            rdata;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [WIDX_W-1:0] word_idx;
    reg_sel_e          sel;

    assign word_idx = bus_addr[ADDR_W-1:1];
    assign sel      = reg_sel_e'(bus_addr[0]);

    always_comb begin
        bank_d       = bank_q;
        bank_d.rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_idx == WIDX_W'(w)) begin
                if (sel == SEL_STATUS) begin
                    bank_d.rdata = src_lvl[w*WORD_W +: WORD_W] & routed[w*WORD_W +: WORD_W];
                end else begin
                    bank_d.rdata = bank_q.en[w*WORD_W +: WORD_W];
                    if (bus_we) begin
                        bank_d.en[w*WORD_W +: WORD_W] = bus_wdata & routed[w*WORD_W +: WORD_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.en    <= FWD_MASK & routed;
            bank_q.rdata <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign en_o    = bank_q.en;
    assign rdata_o = bank_q.rdata;
endmodule

// File: rtl/irq_agg_parent.sv
// Next-state of every parent line from sources, effective enable and routing.
module irq_agg_parent
    import irq_agg_pkg::*;
#(
    parameter int NUM_WORDS   = 2,
    parameter int NUM_PARENTS = 2
) (
    input  logic [NUM_WORDS*WORD_W-1:0]             src_lvl,
    input  logic [NUM_WORDS*WORD_W-1:0]             eff_en,
    input  logic [NUM_PARENTS*NUM_WORDS*WORD_W-1:0] route,
    output logic [NUM_PARENTS-1:0]                  hit_o
);
    localparam int SRC_W = NUM_WORDS * WORD_W;

    logic [SRC_W-1:0] live;
    assign live = src_lvl & eff_en;

    for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_parent
        logic [NUM_WORDS-1:0] word_hit;
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            assign word_hit[w] = |(live[w*WORD_W +: WORD_W] &
                                   route[(p*NUM_WORDS + w)*WORD_W +: WORD_W]);
        end
        assign hit_o[p] = |word_hit;
    end
endmodule

// File: rtl/lvl_irq_aggregator.sv
module lvl_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_WORDS   = 2,
    parameter int NUM_PARENTS = 2,
    parameter int ADDR_W      = 3,
    parameter logic [NUM_PARENTS*NUM_WORDS*WORD_W-1:0] ROUTE_MASK = '1,
    parameter logic [NUM_WORDS*WORD_W-1:0]             FWD_MASK   = '0,
    parameter logic [NUM_WORDS*WORD_W-1:0]             WAKE_SET   = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_WORDS*WORD_W-1:0] irq_src,
    input  logic                        suspend,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic [WORD_W-1:0]           bus_rdata,
    output logic [NUM_PARENTS-1:0]      parent_irq
);
    localparam int SRC_W = NUM_WORDS * WORD_W;

    typedef struct packed {
        logic [NUM_PARENTS-1:0] irq;
    } out_t;

    logic [NUM_PARENTS*SRC_W-1:0] route;
    logic [SRC_W-1:0]             routed;
    logic [SRC_W-1:0]             en_stored;
    logic [SRC_W-1:0]             eff_en;
    logic [NUM_PARENTS-1:0]       hit;
    out_t                         out_d, out_q;

    irq_route_mask #(
        .NUM_WORDS  (NUM_WORDS),
        .NUM_PARENTS(NUM_PARENTS),
        .ROUTE_MASK (ROUTE_MASK)
    ) u_route (
        .route_o (route),
        .routed_o(routed)
    );

    irq_agg_regbank #(
        .NUM_WORDS(NUM_WORDS),
        .ADDR_W   (ADDR_W),
        .FWD_MASK (FWD_MASK)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .src_lvl  (irq_src),
        .routed   (routed),
        .en_o     (en_stored),
        .rdata_o  (bus_rdata)
    );

    // Wake sources are added on top of the stored enable only while suspended.
    assign eff_en = en_stored | ((suspend ? WAKE_SET : '0) & routed);

    irq_agg_parent #(
        .NUM_WORDS  (NUM_WORDS),
        .NUM_PARENTS(NUM_PARENTS)
    ) u_parent (
        .src_lvl(irq_src),
        .eff_en (eff_en),
        .route  (route),
        .hit_o  (hit)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign parent_irq = out_q.irq;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int NUM_WORDS   = 2,
    parameter int NUM_PARENTS = 2,
    parameter int ADDR_W      = 3,
    parameter logic [NUM_PARENTS*NUM_WORDS*WORD_W-1:0] ROUTE_MASK = '1,
    parameter logic [NUM_WORDS*WORD_W-1:0]             FWD_MASK   = '0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_WORDS*WORD_W-1:0] irq_src,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic [WORD_W-1:0]           bus_wdata,
    input logic [WORD_W-1:0]           bus_rdata,
    input logic [NUM_PARENTS-1:0]      parent_irq,
    input logic [NUM_WORDS*WORD_W-1:0] en_stored
);
    localparam int SRC_W = NUM_WORDS * WORD_W;

    logic [SRC_W-1:0] covered;
    always_comb begin
        covered = '0;
        for (int p = 0; p < NUM_PARENTS; p++) begin
            covered = covered | ROUTE_MASK[p*SRC_W +: SRC_W];
        end
    end

    assert_reset_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_stored == (FWD_MASK & covered)));

    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr[ADDR_W-1:1]) >= NUM_WORDS) |=> (bus_rdata == '0));

    assert_status_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[0]) |=> $stable(en_stored));

    assert_quiet_sources_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src == '0) |=> (parent_irq == '0));

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wr
        assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && (bus_addr == ADDR_W'(2*w))) |=>
            (en_stored[w*WORD_W +: WORD_W] ==
             ($past(bus_wdata) & covered[w*WORD_W +: WORD_W])));
    end
endmodule

bind lvl_irq_aggregator irq_agg_checker #(
    .NUM_WORDS  (NUM_WORDS),
    .NUM_PARENTS(NUM_PARENTS),
    .ADDR_W     (ADDR_W),
    .ROUTE_MASK (ROUTE_MASK),
    .FWD_MASK   (FWD_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .parent_irq(parent_irq),
    .en_stored (en_stored)
);

// File: tb/sim_lvl_irq_aggregator.sv
module sim_lvl_irq_aggregator;
    localparam int NW = 2;
    localparam int NP = 2;
    localparam int AW = 3;
    // slot p*NW+w: p0w0, p0w1, p1w0, p1w1 (R6)
    localparam logic [NP*NW*32-1:0] ROUTE = {32'h0000_00FF, 32'hFFFF_0000,
                                             32'h00FF_00FF, 32'h0000_FFFF};
    localparam logic [NW*32-1:0] FWD  = {32'h0000_0F0F, 32'h0000_00F0};
    localparam logic [NW*32-1:0] WAKE = {32'h0001_0000, 32'h8000_0001};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NW*32-1:0] src = '0;
    logic susp = 1'b0;
    logic [AW-1:0] addr = '0;
    logic we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP-1:0] pirq;

    // default-parameter instance for the all-ones routing case
    logic [63:0] d_src = '0;
    logic [2:0]  d_addr = '0;
    logic        d_we = 1'b0;
    logic [31:0] d_wdata = '0;
    logic [31:0] d_rdata;
    logic [1:0]  d_pirq;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] en_m [NW];

    always #5 clk = ~clk;

    lvl_irq_aggregator #(
        .NUM_WORDS(NW), .NUM_PARENTS(NP), .ADDR_W(AW),
        .ROUTE_MASK(ROUTE), .FWD_MASK(FWD), .WAKE_SET(WAKE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(src), .suspend(susp),
        .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .parent_irq(pirq)
    );

    lvl_irq_aggregator u1 (
        .clk(clk), .rst_n(rst_n), .irq_src(d_src), .suspend(1'b0),
        .bus_addr(d_addr), .bus_we(d_we), .bus_wdata(d_wdata),
        .bus_rdata(d_rdata), .parent_irq(d_pirq)
    );

    function automatic logic [31:0] rt(int p, int w);
        return ROUTE[(p*NW + w)*32 +: 32];
    endfunction

    function automatic logic [31:0] cov(int w);
        logic [31:0] m = '0;
        for (int p = 0; p < NP; p++) m |= rt(p, w);
        return m;
    endfunction

    function automatic logic [NP-1:0] exp_irq(logic [NW*32-1:0] s, logic sp);
        logic [NP-1:0] r = '0;
        for (int p = 0; p < NP; p++)
            for (int w = 0; w < NW; w++) begin
                logic [31:0] e = en_m[w] | (sp ? (WAKE[w*32 +: 32] & cov(w)) : 32'h0);
                if ((s[w*32 +: 32] & e & rt(p, w)) != 0) r[p] = 1'b1;
            end
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(logic [AW-1:0] a, logic [NW*32-1:0] s);
        int w = int'(a[AW-1:1]);
        if (w >= NW) return 32'h0;
        if (a[0]) return s[w*32 +: 32] & cov(w);
        return en_m[w];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply inputs, wait one rising edge, sample on the falling edge, then update the model.
    task automatic step(logic [NW*32-1:0] s, logic sp, logic [AW-1:0] a, logic w_en, logic [31:0] d);
        logic [NP-1:0] ei;
        logic [31:0]   er;
        src = s; susp = sp; addr = a; we = w_en; wdata = d;
        ei = exp_irq(s, sp);
        er = exp_rd(a, s);
        @(posedge clk);
        @(negedge clk);
        check(sp ? "R5/R7 parent" : "R5/R9 parent", 32'(pirq), 32'(ei));
        check(int'(a[AW-1:1]) >= NW ? "R8 rdata" : (a[0] ? "R4/R10 rdata" : "R1/R2 rdata"), rdata, er);
        if (w_en && !a[0] && int'(a[AW-1:1]) < NW) en_m[int'(a[AW-1:1])] = d & cov(int'(a[AW-1:1]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int w = 0; w < NW; w++) en_m[w] = FWD[w*32 +: 32] & cov(w);
        repeat (3) @(negedge clk);
        // R3: outputs quiet during reset
        check("R3 reset irq", 32'(pirq), 32'h0);
        check("R3 reset rdata", rdata, 32'h0);
        rst_n = 1'b1;

        // R3: enable holds forwarding mask clipped to routed bits
        step('0, 0, 3'd0, 0, 0);
        check("R3 fwd w0", rdata, 32'h0000_00F0);
        step('0, 0, 3'd2, 0, 0);
        check("R3 fwd w1", rdata, 32'h0000_000F);
        // R4: status shows routed raw levels
        step({32'hFFFF_FFFF, 32'hFFFF_FFFF}, 0, 3'd3, 0, 0);
        check("R4 status w1", rdata, 32'h00FF_00FF);
        // R4: status write ignored, read enable after
        step('0, 0, 3'd1, 1, 32'h0);
        step('0, 0, 3'd0, 0, 0);
        check("R4 enable after status write", rdata, 32'h0000_00F0);
        // R8: unmapped write/read
        step('0, 0, 3'd5, 1, 32'hFFFF_FFFF);
        step('0, 0, 3'd4, 1, 32'hFFFF_FFFF);
        check("R8 unmapped read", rdata, 32'h0);
        // R2: write clipped to routed bits
        step('0, 0, 3'd2, 1, 32'hFFFF_FFFF);
        step('0, 0, 3'd2, 0, 0);
        check("R2 readback w1", rdata, 32'h00FF_00FF);
        step('0, 0, 3'd0, 1, 32'hFFFF_FFFF);
        // R6: routing by slot
        step({32'h0, 32'h0010_0000}, 0, 3'd0, 0, 0);
        step({32'h0, 32'h0010_0000}, 0, 3'd0, 0, 0);
        check("R6 w0 bit20 -> p1", 32'(pirq), 32'h2);
        step({32'h0004_0000, 32'h0}, 0, 3'd0, 0, 0);
        check("R6 w1 bit18 -> p0", 32'(pirq), 32'h1);
        step({32'h0000_0008, 32'h0}, 0, 3'd0, 0, 0);
        check("R6 w1 bit3 -> both", 32'(pirq), 32'h3);
        // R9: held level keeps output, drop clears one cycle later
        for (int i = 0; i < 3; i++) step({32'h0000_0008, 32'h0}, 0, 3'd0, 0, 0);
        step('0, 0, 3'd0, 0, 0);
        check("R9 drop", 32'(pirq), 32'h0);
        // R7: suspend adds wake set, writes land in stored enable, resume restores
        step('0, 0, 3'd0, 1, 32'h0);
        step({32'h0, 32'h8000_0001}, 1, 3'd0, 0, 0);
        check("R7 wake while suspended", 32'(pirq), 32'h3);
        step({32'h0, 32'h8000_0001}, 1, 3'd0, 1, 32'h0000_0001);
        step({32'h0, 32'h8000_0001}, 0, 3'd0, 0, 0);
        check("R7 resume stored enable", 32'(pirq), 32'h1);
        check("R7 stored enable", rdata, 32'h0000_0001);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [NW*32-1:0] s = {$urandom, $urandom} & {$urandom, $urandom};
            step(s, ($urandom % 5) == 0, AW'($urandom), ($urandom % 3) == 0, $urandom);
        end

        // R6 default routing: all sources reach all parents
        d_addr = 3'd0; d_we = 1'b1; d_wdata = 32'h0000_0010;
        @(negedge clk);
        d_we = 1'b0; d_src = 64'h10; d_addr = 3'd3;
        @(negedge clk);
        check("R6 default routing", 32'(d_pirq), 32'h3);
        d_src = 64'hFFFF_FFFF_0000_0000;
        @(negedge clk);
        check("R6 default status", d_rdata, 32'hFFFF_FFFF);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule